// File: doc/BRIEF.md
# PWM-Synchronous Clock Dither Tune Generator

This block produces a small trim code for an on-chip oscillator. The code moves in lock step with a PWM time base, so the system clock, and with it the PWM switching frequency, drifts over a few percent and the switching energy is spread over a wider band. A one-cycle pulse marks each wrap of the PWM period counter. A rollover counter counts these pulses and its upper bits pick the trim code.

Three modes exist. In fixed mode the trim code is a static base value. In sequence mode the code walks through eight slots: the base value and seven further values. In pseudo-random mode the code is the low bits of a 15-bit maximal-length shift register, which steps once every eight rollovers. The output is registered. The analog oscillator, the PWM counter and register decoding sit outside the block.

Top module: `ditherTuneGen`

## Requirements
- R1: While `rst` is high at a rising edge, `trimOut` becomes 0, the rollover counter becomes 0 and the shift register is loaded with 15'h0001, so in random mode the first code after reset is 4'h1.
- R2: With `seqEn` and `rndEn` both low, `trimOut` equals the `baseTune` of the previous cycle, whatever the rollovers.
- R3: The 6-bit rollover counter adds one at each rising edge where `rollPulse` is high and wraps from 63 to 0.
- R4: With `seqEn` high and `rndEn` low, `trimOut` takes the slot indexed by counter bits [5:3], one clock after the counter changes. Slot 0 is `baseTune` and slot k (1..7) is `seqTunes[4k-1:4k-4]`.
- R5: With `rndEn` high, `trimOut` equals bits [3:0] of the shift register from the previous cycle.
- R6: The shift register moves left by one with new bit 0 = bit 14 XOR bit 13 (polynomial x^15+x^14+1). It steps exactly once for each change of counter bit 3, in every mode, and holds otherwise.
- R7: With both enables high, random mode wins over sequence mode.
- R8: Rollover pulses on consecutive cycles each count, and each change of counter bit 3 still gives exactly one register step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rollPulse | input | 1 | One pulse for each PWM period wrap |
| seqEn | input | 1 | Sequence mode enable |
| rndEn | input | 1 | Pseudo-random mode enable |
| baseTune | input | 4 | Base trim value, also sequence slot 0 |
| seqTunes | input | 28 | Sequence slots 1..7, 4 bits each, slot 1 in the lowest bits |
| trimOut | output | 4 | Registered trim code |

## Verification
The bench builds the block with its default parameters: a 4-bit trim, a 6-bit counter, eight slots and a 15-bit register. With these values a full counter wrap takes only 64 pulses, so the wrap back to slot 0 and every slot index can be reached in a short run. A dozen register steps can then be compared against a model built from the polynomial. Back-to-back pulses check that edge detection on bit 3 neither misses nor doubles a step.

// File: rtl/ditherPkg.sv
package ditherPkg;

  typedef enum logic [1:0] {
    MODE_FIXED = 2'd0,
    MODE_SEQ   = 2'd1,
    MODE_RAND  = 2'd2
  } ditherMode_e;

  typedef struct packed {
    logic        lfsrStep;
    ditherMode_e mode;
  } ditherStb_t;

endpackage

// File: rtl/ditherCtrl.sv
module ditherCtrl
  import ditherPkg::*;
#(
  parameter int CNT_W = 6,
  parameter int SLOTS = 8,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int STEP_BIT = CNT_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rollPulse,
  input  logic             seqEn,
  input  logic             rndEn,
  output ditherStb_t       stb,
  output logic [IDX_W-1:0] seqIdx
);

  logic [CNT_W-1:0] rollCnt;
  logic             stepBitQ;

  // Rollover counter and a delayed copy of its step bit (R3, R6)
  always_ff @(posedge clk) begin
    if (rst) begin
      rollCnt  <= '0;
      stepBitQ <= 1'b0;
    end else begin
      if (rollPulse) rollCnt <= rollCnt + 1'b1;
      stepBitQ <= rollCnt[STEP_BIT];
    end
  end

  always_comb begin
    stb.lfsrStep = rollCnt[STEP_BIT] ^ stepBitQ;
    if (rndEn)      stb.mode = MODE_RAND;   // R7 priority
    else if (seqEn) stb.mode = MODE_SEQ;
    else            stb.mode = MODE_FIXED;
  end

  assign seqIdx = rollCnt[CNT_W-1 -: IDX_W];

endmodule

// File: rtl/ditherPath.sv
module ditherPath
  import ditherPkg::*;
#(
  parameter int TUNE_W = 4,
  parameter int SLOTS  = 8,
  parameter int LFSR_W = 15,
  parameter int TAP_HI = 15,
  parameter int TAP_LO = 14,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 15'h0001,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  ditherStb_t                  stb,
  input  logic [IDX_W-1:0]            seqIdx,
  input  logic [TUNE_W-1:0]           baseTune,
  input  logic [(SLOTS-1)*TUNE_W-1:0] seqTunes,
  output logic [TUNE_W-1:0]           trimOut
);

  logic [LFSR_W-1:0] lfsrQ;
  logic              feedBit;
  logic [TUNE_W-1:0] slotVal [SLOTS];

  assign feedBit = lfsrQ[TAP_HI-1] ^ lfsrQ[TAP_LO-1];

  always_ff @(posedge clk) begin
    if (rst)               lfsrQ <= LFSR_SEED;
    else if (stb.lfsrStep) lfsrQ <= {lfsrQ[LFSR_W-2:0], feedBit};
  end

  assign slotVal[0] = baseTune;
  for (genvar k = 1; k < SLOTS; k++) begin : gSlot
    assign slotVal[k] = seqTunes[(k-1)*TUNE_W +: TUNE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trimOut <= '0;
    end else begin
      case (stb.mode)
        MODE_RAND: trimOut <= lfsrQ[TUNE_W-1:0];
        MODE_SEQ:  trimOut <= slotVal[seqIdx];
        default:   trimOut <= baseTune;
      endcase
    end
  end

endmodule

// File: rtl/ditherTuneGen.sv
module ditherTuneGen
  import ditherPkg::*;
#(
  parameter int TUNE_W = 4,
  parameter int CNT_W  = 6,
  parameter int SLOTS  = 8,
  parameter int LFSR_W = 15,
  parameter int TAP_HI = 15,
  parameter int TAP_LO = 14,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 15'h0001,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rollPulse,
  input  logic                        seqEn,
  input  logic                        rndEn,
  input  logic [TUNE_W-1:0]           baseTune,
  input  logic [(SLOTS-1)*TUNE_W-1:0] seqTunes,
  output logic [TUNE_W-1:0]           trimOut
);

  ditherStb_t       stb;
  logic [IDX_W-1:0] seqIdx;

  ditherCtrl #(.CNT_W(CNT_W), .SLOTS(SLOTS)) ctrl_i (
    .clk(clk), .rst(rst), .rollPulse(rollPulse),
    .seqEn(seqEn), .rndEn(rndEn), .stb(stb), .seqIdx(seqIdx)
  );

  ditherPath #(
    .TUNE_W(TUNE_W), .SLOTS(SLOTS), .LFSR_W(LFSR_W),
    .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .LFSR_SEED(LFSR_SEED)
  ) path_i (
    .clk(clk), .rst(rst), .stb(stb), .seqIdx(seqIdx),
    .baseTune(baseTune), .seqTunes(seqTunes), .trimOut(trimOut)
  );

endmodule

// File: rtl/ditherTuneChk.sv
module ditherTuneChk
  import ditherPkg::*;
#(
  parameter int TUNE_W = 4,
  parameter int IDX_W  = 3,
  parameter int LFSR_W = 15,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 15'h0001
) (
  input logic              clk,
  input logic              rst,
  input ditherStb_t        stb,
  input logic [IDX_W-1:0]  seqIdx,
  input logic [TUNE_W-1:0] baseTune,
  input logic [LFSR_W-1:0] lfsrQ,
  input logic [TUNE_W-1:0] trimOut
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (trimOut == '0 && lfsrQ == LFSR_SEED));

  assert_fixed_base_R2: assert property (@(posedge clk) disable iff (rst)
    stb.mode == MODE_FIXED |=> trimOut == $past(baseTune));

  assert_slot0_base_R4: assert property (@(posedge clk) disable iff (rst)
    (stb.mode == MODE_SEQ && seqIdx == '0) |=> trimOut == $past(baseTune));

  assert_rand_low_bits_R5: assert property (@(posedge clk) disable iff (rst)
    stb.mode == MODE_RAND |=> trimOut == $past(lfsrQ[TUNE_W-1:0]));

  assert_lfsr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !stb.lfsrStep |=> $stable(lfsrQ));

  assert_lfsr_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    lfsrQ != '0);

endmodule

bind ditherPath ditherTuneChk #(
  .TUNE_W(TUNE_W), .IDX_W(IDX_W), .LFSR_W(LFSR_W), .LFSR_SEED(LFSR_SEED)
) chk_i (
  .clk(clk), .rst(rst), .stb(stb), .seqIdx(seqIdx),
  .baseTune(baseTune), .lfsrQ(lfsrQ), .trimOut(trimOut)
);

// File: tb/ditherTuneGen_tb.sv
module ditherTuneGen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rollPulse = 1'b0;
  logic        seqEn = 1'b0;
  logic        rndEn = 1'b0;
  logic [3:0]  baseTune = 4'h5;
  logic [27:0] seqTunes;
  logic [3:0]  trimOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [5:0]  modelCnt = '0;
  logic [14:0] modelLfsr = 15'h0001;

  always #(CLK_PERIOD/2) clk = ~clk;

  ditherTuneGen dut_i (
    .clk(clk), .rst(rst), .rollPulse(rollPulse), .seqEn(seqEn),
    .rndEn(rndEn), .baseTune(baseTune), .seqTunes(seqTunes), .trimOut(trimOut)
  );

  // {seqEn, rndEn, useModel, pad, rolls[7:0], expect[3:0]}
  // Slots: 0=5 (base), k = 5+3k -> 8,B,E,1,4,7,A
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0,1'b0,1'b0,1'b0, 8'd0,  4'h5},  // fixed
    {1'b0,1'b0,1'b0,1'b0, 8'd8,  4'h5},  // fixed, count 8
    {1'b1,1'b0,1'b0,1'b0, 8'd0,  4'h8},  // slot 1
    {1'b1,1'b0,1'b0,1'b0, 8'd8,  4'hB},  // count 16, slot 2
    {1'b1,1'b0,1'b0,1'b0, 8'd16, 4'h1},  // count 32, slot 4
    {1'b1,1'b0,1'b0,1'b0, 8'd24, 4'hA},  // count 56, slot 7
    {1'b1,1'b0,1'b0,1'b0, 8'd8,  4'h5},  // count wraps to 0
    {1'b1,1'b0,1'b0,1'b0, 8'd7,  4'h5},  // count 7
    {1'b1,1'b0,1'b0,1'b0, 8'd1,  4'h8},  // count 8
    {1'b0,1'b1,1'b1,1'b0, 8'd0,  4'h0},  // random
    {1'b0,1'b1,1'b1,1'b0, 8'd8,  4'h0},
    {1'b0,1'b1,1'b1,1'b0, 8'd3,  4'h0},  // no bit-3 change
    {1'b0,1'b1,1'b1,1'b0, 8'd5,  4'h0},
    {1'b1,1'b1,1'b1,1'b0, 8'd8,  4'h0},  // both enables
    {1'b1,1'b1,1'b1,1'b0, 8'd16, 4'h0}
  };

  function automatic logic [14:0] lfsrNext(input logic [14:0] q);
    return {q[13:0], q[14] ^ q[13]};
  endfunction

  task automatic modelRoll();
    logic [5:0] old = modelCnt;
    modelCnt = modelCnt + 6'd1;
    if (old[3] != modelCnt[3]) modelLfsr = lfsrNext(modelLfsr);
  endtask

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: trimOut=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rollSpaced(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rollPulse = 1'b1;
      modelRoll();
      @(negedge clk) rollPulse = 1'b0;
    end
  endtask

  task automatic rollBackToBack(input int n);
    @(negedge clk) rollPulse = 1'b1;
    for (int i = 0; i < n; i++) begin
      modelRoll();
      @(negedge clk);
    end
    rollPulse = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int k = 1; k < 8; k++) seqTunes[(k-1)*4 +: 4] = 4'(5 + 3*k);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    modelCnt = '0;
    modelLfsr = 15'h0001;

    // Table walk: R2 fixed, R3 wrap, R4 sequence, R5 R6 random, R7 priority
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] e = VEC[v];
      string tag;
      @(negedge clk);
      seqEn = e[15];
      rndEn = e[14];
      rollSpaced(int'(e[11:4]));
      settle();
      if (e[13]) begin
        tag = e[15] ? "R7" : "R5 R6";
        check(tag, trimOut, modelLfsr[3:0]);
      end else begin
        tag = e[15] ? "R4 R3" : "R2";
        check(tag, trimOut, e[3:0]);
      end
    end

    // R1: reset clears output and reseeds the register
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    check("R1 during reset", trimOut, 4'h0);
    @(negedge clk) rst = 1'b0;
    modelCnt = '0;
    modelLfsr = 15'h0001;
    seqEn = 1'b0;
    rndEn = 1'b1;
    settle();
    check("R1 seed", trimOut, 4'h1);

    // R8: back-to-back rollovers from a cleared counter
    seqEn = 1'b1;
    rndEn = 1'b0;
    rollBackToBack(16);
    settle();
    check("R8 R4 count", trimOut, 4'hB);
    rndEn = 1'b1;
    settle();
    check("R8 R6 two steps", trimOut, modelLfsr[3:0]);
    check("R8 R6 value", trimOut, 4'h4);

    // R2: one-clock latency of the base value in fixed mode
    seqEn = 1'b0;
    rndEn = 1'b0;
    settle();
    @(negedge clk) baseTune = 4'h9;
    @(negedge clk);
    check("R2 latency", trimOut, 4'h9);

    // R4: slot 0 follows a changed base value
    rollSpaced(48);  // count 16 + 48 = 64 -> 0
    seqEn = 1'b1;
    settle();
    check("R4 R3 slot0 wrap", trimOut, 4'h9);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule